// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits beside a configuration word stream and watches each 32-bit word as it is handed over. It counts accepted words from the start of an image and samples two header positions. From one it learns whether the image is encrypted. From the other it learns whether the image is compressed. It combines these two facts with the configured bus width and produces a clock-to-data ratio code. That code tells a downstream clock generator how many data clocks to spend on each word.

The block only observes the stream, so both `in_valid` and `in_ready` are inputs and a word counts only when both are high. A pulse on `sop` starts a new image. An image that ends before the second header word arrives cannot be classified. In that case the block raises an error flag and leaves the ratio at its neutral value.

Top module: `hdr_ratio_sel`

## Requirements
- R1: A word counts only in a cycle where `in_valid` and `in_ready` are both 1. Words are indexed from 0 since the last `sop`, and a word accepted in the same cycle as `sop` is index 0.
- R2: The image is encrypted when bits [3:2] of the word at index 69 are anything other than 00.
- R3: The image is compressed when bit 1 of the word at index 229 is 0. A 1 in that bit means the image is not compressed.
- R4: An image that is neither compressed nor encrypted yields code 0 (x1) at either width.
- R5: With `wide` = 0 (16-bit), a compressed image yields code 2 (x4), whether or not it is encrypted. An image that is only encrypted yields code 1 (x2).
- R6: With `wide` = 1 (32-bit), every code other than 0 is one higher: 3 (x8) when compressed and 2 (x4) when only encrypted. `wide` is sampled in the cycle that word 229 is accepted, and later changes have no effect.
- R7: `decided` rises in the cycle after word 229 is accepted, and `ratio` takes its value in that same cycle. While `decided` is 0, `ratio` is 0. While `decided` is 1, `ratio` holds until the next `sop`.
- R8: If a word is accepted with `in_last` = 1 before index 229, `short_err` rises in the next cycle and `decided` stays 0. A last word at index 229 itself decides normally and raises no error.
- R9: `sop` clears `decided`, `short_err`, `ratio`, the encryption flag and the word count, effective from the next cycle.
- R10: The word counter saturates and does not wrap. Words beyond index 229 are never taken as header words, however long the image is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop | input | 1 | Start-of-image pulse |
| in_valid | input | 1 | Word offered on the observed stream |
| in_ready | input | 1 | Word taken on the observed stream |
| in_data | input | 32 | Observed configuration word |
| in_last | input | 1 | Marks the final word of the image |
| wide | input | 1 | 1 selects 32-bit configuration width, 0 selects 16-bit |
| ratio | output | 2 | Ratio code: 0=x1, 1=x2, 2=x4, 3=x8 |
| decided | output | 1 | Ratio is valid for the current image |
| short_err | output | 1 | Image ended before it could be classified |

## Verification
Two functions can fall in the same cycle: starting an image and counting a word. The bench always raises `sop` together with the first accepted word, so the clear and the count happen at once. It then checks that the header positions still land on the right words. A second coincidence is the end-of-image marker arriving on word 229 itself. There the decision and the short-image check meet in one cycle, and the bench expects a ratio with no error. In both cases a behavioural reference model tracks index, flags and ratio with plain integers and is compared with the outputs every clock.

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel #(
  parameter int WORD_W   = 32,
  parameter int ENC_IDX  = 69,
  parameter int CMP_IDX  = 229,
  parameter int ENC_LSB  = 2,
  parameter int ENC_BITS = 2,
  parameter int CMP_BIT  = 1,
  parameter int RATIO_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sop,
  input  logic               in_valid,
  input  logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_last,
  input  logic               wide,
  output logic [RATIO_W-1:0] ratio,
  output logic               decided,
  output logic               short_err
);
  localparam int CNT_W = $clog2(CMP_IDX + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ENC_POS = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_POS = CNT_W'(CMP_IDX);

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   idx;
  logic               accept;
  logic               enc_q;
  logic               enc_now;
  logic               cmp_now;
  logic [RATIO_W-1:0] ratio_nxt;

  assign accept  = in_valid & in_ready;
  assign idx     = sop ? '0 : cnt;
  assign enc_now = |in_data[ENC_LSB +: ENC_BITS];
  assign cmp_now = ~in_data[CMP_BIT];

  always_comb begin
    if (!cmp_now && !enc_q)
      ratio_nxt = '0;
    else
      ratio_nxt = (cmp_now ? RATIO_W'(2) : RATIO_W'(1)) + RATIO_W'(wide);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      enc_q     <= 1'b0;
      decided   <= 1'b0;
      short_err <= 1'b0;
      ratio     <= '0;
    end else begin
      if (sop) begin
        cnt       <= '0;
        enc_q     <= 1'b0;
        decided   <= 1'b0;
        short_err <= 1'b0;
        ratio     <= '0;
      end
      if (accept) begin
        if (idx != CNT_MAX) cnt <= idx + 1'b1;
        if (idx == ENC_POS) enc_q <= enc_now;
        if (idx == CMP_POS) begin
          decided <= 1'b1;
          ratio   <= ratio_nxt;
        end
        if (in_last && idx < CMP_POS) short_err <= 1'b1;
      end
    end
  end
endmodule

module hdr_ratio_sel_chk #(
  parameter int RATIO_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sop,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_last,
  input logic               wide,
  input logic [RATIO_W-1:0] ratio,
  input logic               decided,
  input logic               short_err
);
  // R7
  ratio_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decided |-> ratio == '0);
  // R7
  decide_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decided) |-> $past(in_valid && in_ready));
  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decided && !sop |=> decided && $stable(ratio));
  // R8
  err_excludes_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(decided && short_err));
  // R8
  err_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_err) |-> $past(in_valid && in_ready && in_last));
  // R9
  sop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> !decided && ratio == '0);
  // R5
  narrow_no_x8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decided) && !$past(wide) |-> ratio != 2'd3);
endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sop(sop), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .wide(wide), .ratio(ratio), .decided(decided),
  .short_err(short_err)
);

// File: tb/hdr_ratio_sel_test.sv
module hdr_ratio_sel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, sop = 0, in_valid = 0, in_ready = 0, in_last = 0, wide = 0;
  logic [31:0] in_data = '0;
  logic [1:0] ratio;
  logic decided, short_err;

  int checks = 0, errors = 0;
  int m_idx = 0, m_enc = 0, m_dec = 0, m_err = 0, m_rat = 0;

  hdr_ratio_sel uut (
    .clk(clk), .rst_n(rst_n), .sop(sop), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .wide(wide), .ratio(ratio),
    .decided(decided), .short_err(short_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: R1..R10
  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_enc = 0; m_dec = 0; m_err = 0; m_rat = 0;
    end else begin
      if (sop) begin
        m_idx = 0; m_enc = 0; m_dec = 0; m_err = 0; m_rat = 0;
      end
      if (in_valid && in_ready) begin
        if (m_idx == 69) m_enc = (in_data[3:2] != 2'b00);
        if (m_idx == 229) begin
          m_dec = 1;
          if (in_data[1] == 1'b0) m_rat = 2 + wide;
          else if (m_enc != 0) m_rat = 1 + wide;
          else m_rat = 0;
        end
        if (in_last && m_idx < 229) m_err = 1;
        m_idx = m_idx + 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R7 model ratio", ratio, m_rat);
    check("R7 model decided", decided, m_dec);
    check("R8 model short_err", short_err, m_err);
  end

  task automatic send_image(int len, logic [1:0] eb, logic cb, logic w, bit stall, bit mark_last);
    wide = w;
    for (int i = 0; i < len; i++) begin
      if (stall && (i % 7 == 3)) begin
        @(negedge clk);
        sop = 0; in_valid = 1; in_ready = 0; in_last = 0; in_data = 32'hC;
        @(negedge clk);
        in_valid = 0; in_ready = 1; in_data = 32'hC;
      end
      @(negedge clk);
      sop = (i == 0); in_valid = 1; in_ready = 1;
      in_last = mark_last && (i == len - 1);
      if (i == 69) in_data = {28'h0, eb, 2'b00};
      else if (i == 229) in_data = {30'h0, cb, 1'b0};
      else in_data = 32'hC;
    end
    @(negedge clk);
    sop = 0; in_valid = 0; in_ready = 0; in_last = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset ratio", ratio, 0);
    check("R7 reset decided", decided, 0);
    check("R8 reset short_err", short_err, 0);

    send_image(240, 2'b00, 1'b1, 1'b0, 0, 1);
    check("R4 plain narrow", ratio, 0); check("R7 decided", decided, 1);
    send_image(240, 2'b00, 1'b1, 1'b1, 0, 1);
    check("R4 plain wide", ratio, 0);
    send_image(240, 2'b00, 1'b0, 1'b0, 0, 1);
    check("R3 R5 compressed narrow", ratio, 2);
    send_image(240, 2'b10, 1'b0, 1'b0, 0, 1);
    check("R5 enc+comp narrow", ratio, 2);
    send_image(240, 2'b01, 1'b1, 1'b0, 0, 1);
    check("R2 R5 enc narrow", ratio, 1);
    send_image(240, 2'b11, 1'b0, 1'b1, 0, 1);
    check("R6 enc+comp wide", ratio, 3);
    send_image(240, 2'b10, 1'b1, 1'b1, 0, 1);
    check("R6 enc wide", ratio, 2);
    wide = 0;
    repeat (3) @(negedge clk);
    check("R6 wide change ignored", ratio, 2);

    send_image(100, 2'b11, 1'b0, 1'b0, 0, 1);
    check("R8 short err", short_err, 1); check("R8 short no decide", decided, 0);
    check("R8 short ratio", ratio, 0);

    send_image(230, 2'b00, 1'b0, 1'b1, 0, 1);
    check("R8 last on 229 no err", short_err, 0); check("R8 last on 229 ratio", ratio, 3);

    send_image(240, 2'b00, 1'b1, 1'b0, 1, 1);
    check("R1 stalls ignored", ratio, 0);

    send_image(120, 2'b11, 1'b0, 1'b1, 0, 0);
    send_image(240, 2'b00, 1'b1, 1'b1, 0, 1);
    check("R9 restart mid image", ratio, 0);

    @(negedge clk); sop = 1;
    @(negedge clk); sop = 0;
    check("R9 sop clears decided", decided, 0);
    check("R9 sop clears ratio", ratio, 0);

    send_image(700, 2'b01, 1'b1, 1'b0, 0, 1);
    check("R10 saturate no resample", ratio, 1);
    check("R10 decided held", decided, 1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule